// File: doc/BRIEF.md
# Vectored Two-Class Interrupt Controller

This block gathers up to 64 level-sensitive interrupt inputs and sends each one to one of two outputs. Sources marked as fast drive a fast request line. All others drive a normal request line, which is gated by a programmable priority threshold. Software reaches the block over a plain 32-bit register bus. The bus carries a word index, a write strobe, write data and combinational read data.

Each source has several controls: an enable bit, a class bit that picks fast or normal, a software force bit and a 4-bit priority. Single enables can be set or cleared without a read-modify-write by writing the source number to one of two command words. Two status words name the source to service next: one for the normal class and one for the fast class. The raw inputs and the pending set of each class can be read back as two 32-bit halves.

Top module: `dualclass_intc`

## Requirements
- R1: Writing a value n below NUM_SRC to byte offset 0x08 (word 2) sets enable bit n and leaves every other enable bit unchanged. Any value of NUM_SRC or more leaves all enables unchanged.
- R2: Writing a value n below NUM_SRC to byte offset 0x0C (word 3) clears enable bit n only. Out-of-range values change nothing.
- R3: Per-source 64-bit state is split into a high half (sources 63..32) and a low half (sources 31..0), with source i at bit i mod 32. The pairs are: enables at 0x10 (high) and 0x14 (low), class at 0x18/0x1C, raw inputs at 0x48/0x4C (read-only), force at 0x50/0x54, normal pending at 0x58/0x5C and fast pending at 0x60/0x64.
- R4: The priority of source 8g+k sits in bits [4k+3:4k] of the word at byte offset 0x20 + 4*(7-g). The group with the highest numbers therefore has the lowest address. The words read back as written.
- R5: A source is live when its input or its force bit is 1 and its enable bit is 1. A live source whose class bit is 1 is fast pending. fiq_o is 1 exactly when some source is fast pending.
- R6: A live source whose class bit is 0 is normal pending. The mask field is bits [4:0] at 0x04 and reads back with bits [31:5] zero. irq_o is 1 when the mask is 31 and some source is normal pending. For any other mask value, irq_o is 1 when some normal pending source has a priority strictly above the mask.
- R7: The word at 0x40 returns {source number, priority}, each as 16 bits, for the normal pending source with the highest priority. On equal priority the higher source number wins. When nothing is normal pending the word reads 0xFFFFFFFF.
- R8: The word at 0x44 returns {number of the highest-numbered fast pending source, 16'h0000}. When nothing is fast pending it reads 0xFFFFFFFF.
- R9: A force bit makes its source pending exactly as an active input would. The raw input words show only the input pins and never the force bits.
- R10: After reset all enable, class, force and priority bits are 0, the mask reads 0x0000001F, the word at 0x00 reads 0, both outputs are 0 and both vector words read 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_word | input | 5 | Register word index (byte offset / 4) |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed word |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs, active high |
| irq_o | output | 1 | Normal-class interrupt request |
| fiq_o | output | 1 | Fast-class interrupt request |

## Verification
The bench builds the block with the default NUM_SRC of 64, so both register halves and all eight priority groups are in use. At this size every source number can be driven through the set and clear commands. Every source can also be made the single pending input, and each of the 16 priority levels can be swept against all 32 mask values. Tie-breaking is reached by giving pairs of sources equal priority. A pseudo-random series of multi-source patterns, with mixed classes and force bits, is compared against a priority search in the bench.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned MAX_SRC = 64;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned PRIO_W  = 4;
   localparam int unsigned MASK_W  = 5;
   localparam int unsigned GROUPS  = MAX_SRC / 8;

   typedef logic [4:0] word_t;

   localparam word_t W_CTRL = 5'd0;
   localparam word_t W_MASK = 5'd1;
   localparam word_t W_SETN = 5'd2;
   localparam word_t W_CLRN = 5'd3;
   localparam word_t W_ENH  = 5'd4;
   localparam word_t W_ENL  = 5'd5;
   localparam word_t W_TYPH = 5'd6;
   localparam word_t W_TYPL = 5'd7;
   localparam word_t W_NVEC = 5'd16;
   localparam word_t W_FVEC = 5'd17;
   localparam word_t W_RAWH = 5'd18;
   localparam word_t W_RAWL = 5'd19;
   localparam word_t W_FRCH = 5'd20;
   localparam word_t W_FRCL = 5'd21;
   localparam word_t W_NPH  = 5'd22;
   localparam word_t W_NPL  = 5'd23;
   localparam word_t W_FPH  = 5'd24;
   localparam word_t W_FPL  = 5'd25;

   localparam logic [MASK_W-1:0] MASK_OPEN = '1;
   localparam logic [WORD_W-1:0] VEC_NONE  = '1;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  word_t                              wr_word,
   input  logic [WORD_W-1:0]                  wr_data,
   output logic [MAX_SRC-1:0]                 en_o,
   output logic [MAX_SRC-1:0]                 typ_o,
   output logic [MAX_SRC-1:0]                 frc_o,
   output logic [MAX_SRC-1:0][PRIO_W-1:0]     prio_o,
   output logic [MASK_W-1:0]                  mask_o
);
   localparam logic [MAX_SRC-1:0] IMPL = {MAX_SRC{1'b1}} >> (MAX_SRC - NUM_SRC);

   logic [2:0] wgrp;
   logic       num_ok;

   assign wgrp   = ~wr_word[2:0];
   assign num_ok = (wr_data < WORD_W'(NUM_SRC));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o   <= '0;
         typ_o  <= '0;
         frc_o  <= '0;
         prio_o <= '0;
         mask_o <= MASK_OPEN;
      end else if (wr_en) begin
         case (wr_word)
            W_MASK: mask_o <= wr_data[MASK_W-1:0];
            W_SETN: if (num_ok) en_o[wr_data[5:0]] <= 1'b1;
            W_CLRN: if (num_ok) en_o[wr_data[5:0]] <= 1'b0;
            W_ENH:  en_o[63:32]  <= wr_data & IMPL[63:32];
            W_ENL:  en_o[31:0]   <= wr_data & IMPL[31:0];
            W_TYPH: typ_o[63:32] <= wr_data & IMPL[63:32];
            W_TYPL: typ_o[31:0]  <= wr_data & IMPL[31:0];
            W_FRCH: frc_o[63:32] <= wr_data & IMPL[63:32];
            W_FRCL: frc_o[31:0]  <= wr_data & IMPL[31:0];
            default: begin
               if (wr_word[4:3] == 2'b01) begin
                  for (int k = 0; k < 8; k++) begin
                     if (IMPL[{wgrp, 3'(k)}])
                        prio_o[{wgrp, 3'(k)}] <= wr_data[4*k +: 4];
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
   parameter int N  = 64,
   parameter int PW = 4,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]         pend_i,
   input  logic [N-1:0][PW-1:0] prio_i,
   output logic                 found_o,
   output logic [IW-1:0]        idx_o,
   output logic [PW-1:0]        prio_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      prio_o  = '0;
      for (int i = 0; i < N; i++) begin
         if (pend_i[i] && (!found_o || prio_i[i] >= prio_o)) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
            prio_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/dualclass_intc.sv
module dualclass_intc
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         bus_word,
   input  logic               bus_we,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int IW = $clog2(MAX_SRC);

   if (NUM_SRC < 8 || NUM_SRC > MAX_SRC || (NUM_SRC % 8) != 0) begin : g_bad_cfg
      $error("NUM_SRC must be a multiple of 8 in 8..64");
   end

   logic [MAX_SRC-1:0]             en_q, typ_q, frc_q, src_ext;
   logic [MAX_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [MASK_W-1:0]              mask_q;
   logic [MAX_SRC-1:0]             live, npend, fpend;
   logic                           n_found, f_found;
   logic [IW-1:0]                  n_idx, f_idx;
   logic [PRIO_W-1:0]              n_prio, f_prio;
   logic [WORD_W-1:0]              nvec, fvec, prio_word;
   logic [2:0]                     rgrp;

   intc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_we),
      .wr_word (bus_word),
      .wr_data (bus_wdata),
      .en_o    (en_q),
      .typ_o   (typ_q),
      .frc_o   (frc_q),
      .prio_o  (prio_q),
      .mask_o  (mask_q)
   );

   always_comb begin
      src_ext = '0;
      src_ext[NUM_SRC-1:0] = src_i;
   end

   assign live  = (src_ext | frc_q) & en_q;
   assign npend = live & ~typ_q;
   assign fpend = live & typ_q;

   intc_pick #(.N(MAX_SRC), .PW(PRIO_W)) u_npick (
      .pend_i  (npend),
      .prio_i  (prio_q),
      .found_o (n_found),
      .idx_o   (n_idx),
      .prio_o  (n_prio)
   );

   intc_pick #(.N(MAX_SRC), .PW(PRIO_W)) u_fpick (
      .pend_i  (fpend),
      .prio_i  ('0),
      .found_o (f_found),
      .idx_o   (f_idx),
      .prio_o  (f_prio)
   );

   assign fiq_o = |fpend;
   assign irq_o = n_found && ((mask_q == MASK_OPEN) || ({1'b0, n_prio} > mask_q));

   assign nvec = n_found ? {16'(n_idx), 16'(n_prio)} : VEC_NONE;
   assign fvec = f_found ? {16'(f_idx), 12'h000, f_prio} : VEC_NONE;

   assign rgrp = ~bus_word[2:0];
   always_comb begin
      for (int k = 0; k < 8; k++) prio_word[4*k +: 4] = prio_q[{rgrp, 3'(k)}];
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_word)
         W_MASK: bus_rdata = {{(WORD_W-MASK_W){1'b0}}, mask_q};
         W_ENH:  bus_rdata = en_q[63:32];
         W_ENL:  bus_rdata = en_q[31:0];
         W_TYPH: bus_rdata = typ_q[63:32];
         W_TYPL: bus_rdata = typ_q[31:0];
         W_NVEC: bus_rdata = nvec;
         W_FVEC: bus_rdata = fvec;
         W_RAWH: bus_rdata = src_ext[63:32];
         W_RAWL: bus_rdata = src_ext[31:0];
         W_FRCH: bus_rdata = frc_q[63:32];
         W_FRCL: bus_rdata = frc_q[31:0];
         W_NPH:  bus_rdata = npend[63:32];
         W_NPL:  bus_rdata = npend[31:0];
         W_FPH:  bus_rdata = fpend[63:32];
         W_FPL:  bus_rdata = fpend[31:0];
         default: if (bus_word[4:3] == 2'b01) bus_rdata = prio_word;
      endcase
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic [4:0]         bus_word,
   input logic               bus_we,
   input logic [31:0]        bus_wdata,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [MAX_SRC-1:0] en,
   input logic [MAX_SRC-1:0] typ,
   input logic [MASK_W-1:0]  mask
);
   logic set_ok, clr_ok, num_bad;
   assign num_bad = bus_wdata >= 32'(NUM_SRC);
   assign set_ok  = bus_we && bus_word == W_SETN && !num_bad;
   assign clr_ok  = bus_we && bus_word == W_CLRN && !num_bad;

   AST_SET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      set_ok |=> en == ($past(en) | (64'd1 << $past(bus_wdata[5:0])))); // R1
   AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |=> en == ($past(en) & ~(64'd1 << $past(bus_wdata[5:0])))); // R2
   AST_BAD_NUM_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_word == W_SETN || bus_word == W_CLRN) && num_bad) |=> $stable(en)); // R1
   AST_FIQ_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> |(en & typ)); // R5
   AST_IRQ_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> |(en & ~typ)); // R6
   AST_HIGH_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (mask != MASK_OPEN && mask >= 5'd15) |-> !irq_o); // R6
endmodule

bind dualclass_intc intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_word  (bus_word),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .en        (en_q),
   .typ       (typ_q),
   .mask      (mask_q)
);

// File: tb/tb_dualclass_intc.sv
`timescale 1ns/1ps
module tb_dualclass_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_word = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_i = '0;
   logic        irq_o, fiq_o;

   int nchk = 0, nfail = 0;
   bit done = 0;

   logic [63:0] m_en = '0, m_typ = '0, m_frc = '0;
   logic [3:0]  m_pr [64];
   logic [4:0]  m_mask = 5'h1f;

   always #2.5 clk = ~clk;

   dualclass_intc #(.NUM_SRC(64)) dut (
      .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_i(src_i),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] w, logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [4:0] w, output logic [31:0] d);
      @(negedge clk);
      bus_word = w;
      #1 d = bus_rdata;
   endtask

   function automatic logic [63:0] m_live();
      return (src_i | m_frc) & m_en;
   endfunction

   function automatic logic [31:0] m_nvec();
      logic [63:0] p = m_live() & ~m_typ;
      for (int pr = 15; pr >= 0; pr--)
         for (int i = 63; i >= 0; i--)
            if (p[i] && m_pr[i] == 4'(pr)) return {16'(i), 16'(pr)};
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] m_fvec();
      logic [63:0] p = m_live() & m_typ;
      for (int i = 63; i >= 0; i--) if (p[i]) return {16'(i), 16'h0};
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic m_irq();
      logic [63:0] p = m_live() & ~m_typ;
      for (int i = 0; i < 64; i++)
         if (p[i] && (m_mask == 5'd31 || {1'b0, m_pr[i]} > m_mask)) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check_state(string tag);
      logic [31:0] a, b;
      logic [63:0] p;
      rd(5'd16, a); chk({"R7 nvec ", tag}, {32'h0, a}, {32'h0, m_nvec()});
      rd(5'd17, a); chk({"R8 fvec ", tag}, {32'h0, a}, {32'h0, m_fvec()});
      p = m_live() & ~m_typ;
      rd(5'd22, a); rd(5'd23, b); chk({"R3 npend ", tag}, {a, b}, p);
      rd(5'd24, a); rd(5'd25, b); chk({"R5 fpend ", tag}, {a, b}, m_live() & m_typ);
      chk({"R6 irq ", tag}, {63'h0, irq_o}, {63'h0, m_irq()});
      chk({"R5 fiq ", tag}, {63'h0, fiq_o}, {63'h0, |(m_live() & m_typ)});
   endtask

   task automatic read_en(string tag);
      logic [31:0] a, b;
      rd(5'd4, a); rd(5'd5, b);
      chk(tag, {a, b}, m_en);
   endtask

   task automatic write_prio();
      for (int g = 0; g < 8; g++) begin
         logic [31:0] w;
         for (int k = 0; k < 8; k++) w[4*k +: 4] = m_pr[8*g+k];
         wr(5'(8 + (7 - g)), w);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, b;
      logic [63:0] lfsr;
      for (int i = 0; i < 64; i++) m_pr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      rd(5'd0, a); chk("R10 ctrl", {32'h0, a}, 64'h0);
      rd(5'd1, a); chk("R10 mask", {32'h0, a}, 64'h1f);
      read_en("R10 enables");
      rd(5'd6, a); rd(5'd7, b); chk("R10 type", {a, b}, 64'h0);
      rd(5'd20, a); rd(5'd21, b); chk("R10 force", {a, b}, 64'h0);
      for (int w = 8; w < 16; w++) begin rd(5'(w), a); chk("R10 prio", {32'h0, a}, 64'h0); end
      rd(5'd16, a); chk("R10 nvec", {32'h0, a}, 64'hFFFF_FFFF);
      rd(5'd17, a); chk("R10 fvec", {32'h0, a}, 64'hFFFF_FFFF);
      chk("R10 outputs", {62'h0, irq_o, fiq_o}, 64'h0);

      // R1 set-by-number sweep
      for (int j = 0; j < 64; j++) begin
         int n = (j * 37) % 64;
         wr(5'd2, 32'(n)); m_en[n] = 1'b1;
         read_en("R1 set by number");
      end
      wr(5'd3, 32'd5); m_en[5] = 1'b0;
      wr(5'd2, 32'd64);  read_en("R1 out of range set");
      wr(5'd2, 32'hFFFF_FFC5); read_en("R1 large set ignored");
      // R2 clear-by-number sweep
      for (int j = 0; j < 64; j++) begin
         int n = (j * 21 + 3) % 64;
         wr(5'd3, 32'(n)); m_en[n] = 1'b0;
         read_en("R2 clear by number");
         if (j == 30) begin wr(5'd3, 32'd99); read_en("R2 out of range clear"); end
      end

      // R4 priority words
      for (int i = 0; i < 64; i++) m_pr[i] = 4'((i * 5 + 3) % 16);
      write_prio();
      for (int g = 0; g < 8; g++) begin
         logic [31:0] w;
         for (int k = 0; k < 8; k++) w[4*k +: 4] = m_pr[8*g+k];
         rd(5'(8 + (7 - g)), a); chk("R4 prio word", {32'h0, a}, {32'h0, w});
      end

      // R3 halves via direct enable words
      wr(5'd4, 32'hFFFF_FFFF); wr(5'd5, 32'hFFFF_FFFF); m_en = '1;
      read_en("R3 enable halves");

      // R7 single-source sweep
      for (int s = 0; s < 64; s++) begin
         src_i = 64'd1 << s;
         check_state("single");
      end
      // R7 ties: s and s+16 share priority, higher wins
      for (int s = 0; s < 48; s++) begin
         src_i = (64'd1 << s) | (64'd1 << (s + 16));
         rd(5'd16, a); chk("R7 tie higher wins", {32'h0, a}, {32'h0, 16'(s + 16), 16'(m_pr[s])});
      end

      // R6 mask sweep over every priority level
      for (int s = 0; s < 16; s++) begin
         src_i = 64'd1 << s;
         for (int m = 0; m < 32; m++) begin
            wr(5'd1, 32'hFFFF_FF00 | 32'(m)); m_mask = 5'(m);
            chk("R6 mask threshold", {63'h0, irq_o}, {63'h0, (m == 31) || (int'(m_pr[s]) > m)});
         end
      end
      rd(5'd1, a); chk("R6 mask readback", {32'h0, a}, 64'h1f);

      // R5 class split, R9 force, mixed patterns
      lfsr = 64'hACE1_2345_6789_BDF1;
      for (int t = 0; t < 120; t++) begin
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         if (t % 20 == 0) begin
            m_typ = {lfsr[31:0], lfsr[63:32]} & {lfsr[47:0], lfsr[63:48]};
            wr(5'd6, m_typ[63:32]); wr(5'd7, m_typ[31:0]);
            m_frc = (t >= 60) ? (lfsr ^ {lfsr[15:0], lfsr[63:16]}) & 64'h0F00_00F0_0300_0C01 : '0;
            wr(5'd20, m_frc[63:32]); wr(5'd21, m_frc[31:0]);
            m_en = lfsr | 64'hF0F0_0000_0000_F0F0;
            wr(5'd4, m_en[63:32]); wr(5'd5, m_en[31:0]);
            m_mask = 5'(t % 13);
            wr(5'd1, 32'(m_mask));
         end
         src_i = (t % 3 == 0) ? 64'h0 : lfsr & {lfsr[31:0], lfsr[63:32]};
         check_state("mixed");
         rd(5'd18, a); rd(5'd19, b); chk("R9 raw shows pins only", {a, b}, src_i);
      end

      // R9 force alone, R5 fast vector picks highest number
      src_i = '0;
      m_en = '1; wr(5'd4, 32'hFFFF_FFFF); wr(5'd5, 32'hFFFF_FFFF);
      m_typ = 64'h8000_0001_0000_0010; wr(5'd6, m_typ[63:32]); wr(5'd7, m_typ[31:0]);
      m_frc = 64'h0000_0001_0000_0011; wr(5'd20, m_frc[63:32]); wr(5'd21, m_frc[31:0]);
      check_state("force only");
      rd(5'd17, a); chk("R8 fast highest", {32'h0, a}, {32'h0, 32'h0020_0000});
      rd(5'd16, a); chk("R9 forced normal", {32'h0, a}, {32'h0, 16'd0, 12'h0, m_pr[0]});
      m_en = '0; wr(5'd4, 0); wr(5'd5, 0);
      check_state("force disabled");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule